// File: doc/BRIEF.md
# Serial Command Register Slave with Frame Length Check

This block is the serial register front end of a motor pre-driver. An external controller talks to it over a four-wire serial link in clock-idle-low mode: data is taken on the rising clock edge and presented after the falling edge. Each transfer is 24 bits long and most significant bit first. It carries a command byte (a two-bit operation code, then a six-bit address) and a 16-bit data word. While the command byte goes in, the block sends back a global status byte. The 16 bits that follow depend on the operation and the address.

The serial pins are oversampled by the chip's system clock through synchronizer stages. The block holds a control register, a configuration register, a sticky status register fed by fault event pulses, and five fixed identification bytes. It counts serial clocks in each chip-select window. A window with any count other than 24 changes nothing and sets a transmission-error flag. A window with no clocks at all is a legal status poll, during which the data output shows the global fault flag. A received frame of all ones is passed to the mode supervisor as a one-cycle indication.

Top module: `spi_cmd_slave`

## Requirements
- R1: `sdoOe` is low whenever `csN` is high and high whenever `csN` is low.
- R2: From the fall of `csN` until the first serial clock rise, `sdo` shows the fault flag, which is the OR of the transmission-error flag, the inverted reset-bar flag, `tsdIn` and the supply/overcurrent summary. A window with zero clocks leaves every register and flag unchanged.
- R3: The returned bits 23..16 are, from MSB: fault flag, transmission error, reset-bar, `tsdIn`, 0, supply/overcurrent summary (OR of all status register bits), 0, `nrdyIn`. After reset, with `tsdIn`=0 and `nrdyIn`=1, this byte is 81h and both writable registers are zero.
- R4: Operation codes are 00 write, 01 read, 10 read-and-clear, 11 identification read. Address 00h selects the control register, 10h the status register and 3Fh the configuration register. Any other address returns zero data for the codes 00, 01 and 10.
- R5: A write changes its register only at the end of a valid 24-clock frame, and the frame returns the register's previous value. Only control bits 9..6 and 4..0 (mask 03DFh) and configuration bits 15..3 (mask FFF8h) can be written. A write to the status register has no effect.
- R6: A frame with a clock count other than 0 or 24 updates no register and sets the transmission-error flag. The next valid 24-clock frame clears that flag.
- R7: An identification read returns 43h at address 00h, 01h at 01h, 75h at 02h, 35h at 03h and 02h at 3Eh, placed in data bits 15..8 with zeros below. Other addresses return zero.
- R8: Each `faultEvt` bit sets a sticky status bit: bits 5..2 go to status bits 7..4 and bits 1..0 go to status bits 1..0. No status bit clears except by read-and-clear.
- R9: A read-and-clear of address 10h clears, at the end of a valid frame, only the status bits it returned. An event arriving in the same cycle, or after the data was captured, stays set.
- R10: A valid frame of FFFFFFh gives a single-cycle `stuckOnes` pulse, clears the reset-bar flag and writes nothing. Any other valid frame sets the reset-bar flag.
- R11: `sdi` is taken on serial clock rises, `sdo` moves to the next bit after each serial clock fall, and every field goes most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the controller |
| csN | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdoOe | output | 1 | Output enable of the `sdo` pad; low releases the pad |
| faultEvt | input | 6 | Fault event pulses (four overcurrent, supply low, supply high) |
| tsdIn | input | 1 | Thermal shutdown level reported in the status byte |
| nrdyIn | input | 1 | Not-ready level reported in the status byte |
| ctrlOut | output | 16 | Control register contents |
| cfgOut | output | 16 | Configuration register contents |
| stuckOnes | output | 1 | One-cycle pulse after a valid all-ones frame |

## Verification
The assertions check, on every cycle, the following. The writable registers move only after a frame-end strobe and never hold a bit outside their write masks. A rejected frame sets the error flag and a valid one clears it. Status bits are sticky, and an incoming event always wins over a clear. The stuck-ones pulse always comes with a cleared reset-bar flag. Only the bench's scenarios can show the serial-level results: the returned bit streams, the previous-value return of a write, the identification bytes, the fault flag during a poll, and the split between bits cleared by a read-and-clear and bits raised while that frame was in flight.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int CMD_BITS   = 8;
  localparam int DATA_BITS  = 16;
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;
  localparam int OP_BITS    = 2;
  localparam int ADDR_BITS  = CMD_BITS - OP_BITS;
  localparam int EVT_BITS   = 6;
  localparam int ID_BITS    = 8;

  typedef enum logic [OP_BITS-1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_RDCLR = 2'b10,
    OP_RDID  = 2'b11
  } opCode_e;

  localparam logic [ADDR_BITS-1:0] ADDR_CTRL = 6'h00;
  localparam logic [ADDR_BITS-1:0] ADDR_STAT = 6'h10;
  localparam logic [ADDR_BITS-1:0] ADDR_CFG  = 6'h3F;

  localparam logic [DATA_BITS-1:0] CTRL_WMASK = 16'h03DF;
  localparam logic [DATA_BITS-1:0] CFG_WMASK  = 16'hFFF8;
  localparam logic [DATA_BITS-1:0] STAT_MASK  = 16'h00F3;

  // Strobes from the frame controller to the datapath, one system clock wide.
  typedef struct packed {
    logic sample;      // serial clock rise inside a frame
    logic sdiBit;      // synchronized data bit aligned with sample
    logic loadStatus;  // first rise: capture status byte
    logic loadData;    // rise closing the command byte
    logic shiftOut;    // serial clock fall after the first rise
    logic commit;      // chip select released after exactly FRAME_BITS rises
    logic reject;      // chip select released after a bad count
    logic pollPhase;   // no rise yet in this window
  } spiStb_t;

  function automatic logic [ID_BITS-1:0] idValue(input logic [ADDR_BITS-1:0] a);
    case (a)
      6'h00:   return 8'h43;
      6'h01:   return 8'h01;
      6'h02:   return 8'h75;
      6'h03:   return 8'h35;
      6'h3E:   return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  // Event pins to status register bit positions.
  function automatic logic [DATA_BITS-1:0] evtMap(input logic [EVT_BITS-1:0] e);
    logic [DATA_BITS-1:0] m;
    m = '0;
    m[7:4] = e[5:2];
    m[1:0] = e[1:0];
    return m;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic syncOut
);
  timeunit 1ns; timeprecision 1ps;

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], pinIn};
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkPin,
  input  logic    csNPin,
  input  logic    sdiPin,
  output spiStb_t stb
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NUM_PINS = 3;
  localparam int CNT_W    = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_CMD   = CNT_W'(CMD_BITS - 1);
  localparam logic [NUM_PINS-1:0] PIN_RST = 3'b010; // chip select idles high

  logic [NUM_PINS-1:0] pinRaw, pinSync;
  logic sclkNow, csNow, sdiNow;
  logic sclkPrev, csPrev;
  logic sclkRise, sclkFall, csRise, csFall, csActive;
  logic [CNT_W-1:0] clkCnt;

  assign pinRaw = {sdiPin, csNPin, sclkPin};

  for (genvar p = 0; p < NUM_PINS; p++) begin : gSync
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[p])) uSync (
      .clk(clk), .rstN(rstN), .pinIn(pinRaw[p]), .syncOut(pinSync[p])
    );
  end

  assign sclkNow = pinSync[0];
  assign csNow   = pinSync[1];
  assign sdiNow  = pinSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkNow;
      csPrev   <= csNow;
    end
  end

  assign sclkRise = sclkNow & ~sclkPrev;
  assign sclkFall = ~sclkNow & sclkPrev;
  assign csRise   = csNow & ~csPrev;
  assign csFall   = ~csNow & csPrev;
  assign csActive = ~csNow;

  // Rise counter, saturating so an overlong frame never aliases to a valid count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          clkCnt <= '0;
    else if (csRise || csFall)                          clkCnt <= '0;
    else if (sclkRise && csActive && clkCnt != CNT_MAX) clkCnt <= clkCnt + 1'b1;
  end

  always_comb begin
    stb            = '0;
    stb.sample     = sclkRise & csActive;
    stb.sdiBit     = sdiNow;
    stb.loadStatus = stb.sample & (clkCnt == '0);
    stb.loadData   = stb.sample & (clkCnt == CNT_CMD);
    stb.shiftOut   = sclkFall & csActive & (clkCnt != '0);
    stb.commit     = csRise & (clkCnt == CNT_FRAME);
    stb.reject     = csRise & (clkCnt != '0) & (clkCnt != CNT_FRAME);
    stb.pollPhase  = (clkCnt == '0);
  end
endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  spiStb_t              stb,
  input  logic [EVT_BITS-1:0]  faultEvt,
  input  logic                 tsdIn,
  input  logic                 nrdyIn,
  output logic                 sdoBit,
  output logic [DATA_BITS-1:0] ctrlQ,
  output logic [DATA_BITS-1:0] cfgQ,
  output logic [DATA_BITS-1:0] statQ,
  output logic                 tfQ,
  output logic                 resbQ,
  output logic                 stuckOnes
);
  timeunit 1ns; timeprecision 1ps;

  localparam int OUT_DATA_TOP = FRAME_BITS - 2;

  logic [FRAME_BITS-1:0] inShift, outShift;
  logic [DATA_BITS-1:0]  statSnap, rdData, clrMask;
  logic [CMD_BITS-1:0]   cmdNow;
  logic [OP_BITS-1:0]    opNow, opFrm;
  logic [ADDR_BITS-1:0]  addrNow, addrFrm;
  logic [DATA_BITS-1:0]  dataFrm;
  logic [7:0]            statusByte;
  logic allOnes, uovOc, fltNow, goodFrame;
  logic wrCtrl, wrCfg, clrStat;

  // Command byte as it stands on the rise that completes it.
  assign cmdNow  = {inShift[CMD_BITS-2:0], stb.sdiBit};
  assign opNow   = cmdNow[CMD_BITS-1 -: OP_BITS];
  assign addrNow = cmdNow[ADDR_BITS-1:0];

  // Fields of the complete frame at chip-select release.
  assign opFrm   = inShift[FRAME_BITS-1 -: OP_BITS];
  assign addrFrm = inShift[DATA_BITS +: ADDR_BITS];
  assign dataFrm = inShift[DATA_BITS-1:0];
  assign allOnes = &inShift;

  assign uovOc      = |statQ;
  assign fltNow     = tfQ | ~resbQ | tsdIn | uovOc;
  assign statusByte = {fltNow, tfQ, resbQ, tsdIn, 1'b0, uovOc, 1'b0, nrdyIn};

  always_comb begin
    rdData = '0;
    if (opNow == OP_RDID) begin
      rdData = {idValue(addrNow), {(DATA_BITS-ID_BITS){1'b0}}};
    end else begin
      case (addrNow)
        ADDR_CTRL: rdData = ctrlQ;
        ADDR_STAT: rdData = statQ;
        ADDR_CFG:  rdData = cfgQ;
        default:   rdData = '0;
      endcase
    end
  end

  assign goodFrame = stb.commit & ~allOnes;
  assign wrCtrl    = goodFrame & (opFrm == OP_WRITE) & (addrFrm == ADDR_CTRL);
  assign wrCfg     = goodFrame & (opFrm == OP_WRITE) & (addrFrm == ADDR_CFG);
  assign clrStat   = goodFrame & (opFrm == OP_RDCLR) & (addrFrm == ADDR_STAT);
  assign clrMask   = clrStat ? statSnap : '0;

  // Receive shifter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           inShift <= '0;
    else if (stb.sample) inShift <= {inShift[FRAME_BITS-2:0], stb.sdiBit};
  end

  // Transmit shifter: status byte on the first rise, addressed data once the command is known.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
    end else if (stb.loadStatus) begin
      outShift <= {statusByte, {DATA_BITS{1'b0}}};
    end else if (stb.loadData) begin
      outShift[OUT_DATA_TOP -: DATA_BITS] <= rdData;
    end else if (stb.shiftOut) begin
      outShift <= {outShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  // Bits reported by a read-and-clear; only these may be cleared later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             statSnap <= '0;
    else if (stb.loadData) statSnap <= ((opNow == OP_RDCLR) && (addrNow == ADDR_STAT)) ? statQ : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      cfgQ  <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= dataFrm & CTRL_WMASK;
      if (wrCfg)  cfgQ  <= dataFrm & CFG_WMASK;
    end
  end

  // Sticky status: new events win over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrMask) | evtMap(faultEvt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tfQ       <= 1'b0;
      resbQ     <= 1'b0;
      stuckOnes <= 1'b0;
    end else begin
      stuckOnes <= stb.commit & allOnes;
      if (stb.reject)      tfQ <= 1'b1;
      else if (stb.commit) tfQ <= 1'b0;
      if (stb.commit)      resbQ <= ~allOnes;
    end
  end

  assign sdoBit = stb.pollPhase ? fltNow : outShift[FRAME_BITS-1];
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclk,
  input  logic                 csN,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdoOe,
  input  logic [EVT_BITS-1:0]  faultEvt,
  input  logic                 tsdIn,
  input  logic                 nrdyIn,
  output logic [DATA_BITS-1:0] ctrlOut,
  output logic [DATA_BITS-1:0] cfgOut,
  output logic                 stuckOnes
);
  timeunit 1ns; timeprecision 1ps;

  spiStb_t              stb;
  logic [DATA_BITS-1:0] statQ;
  logic                 tfQ, resbQ;

  spi_frame_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkPin(sclk), .csNPin(csN), .sdiPin(sdi), .stb(stb)
  );

  spi_reg_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .faultEvt(faultEvt), .tsdIn(tsdIn),
    .nrdyIn(nrdyIn), .sdoBit(sdo), .ctrlQ(ctrlOut), .cfgQ(cfgOut), .statQ(statQ),
    .tfQ(tfQ), .resbQ(resbQ), .stuckOnes(stuckOnes)
  );

  // Pad released straight from the pin, with no synchronizer lag.
  assign sdoOe = ~csN;
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk
  import spi_cmd_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 commit,
  input logic                 reject,
  input logic                 loadStatus,
  input logic                 loadData,
  input logic                 shiftOut,
  input logic [EVT_BITS-1:0]  faultEvt,
  input logic [DATA_BITS-1:0] statQ,
  input logic                 tfQ,
  input logic                 resbQ,
  input logic [DATA_BITS-1:0] ctrlOut,
  input logic [DATA_BITS-1:0] cfgOut,
  input logic                 stuckOnes
);
  timeunit 1ns; timeprecision 1ps;

  assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> ($stable(ctrlOut) && $stable(cfgOut)));

  assert_write_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlOut & ~CTRL_WMASK) == '0) && ((cfgOut & ~CFG_WMASK) == '0));

  assert_tf_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    reject |=> tfQ);

  assert_tf_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !tfQ);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> ((statQ & $past(statQ)) == $past(statQ)));

  assert_status_field_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statQ & ~STAT_MASK) == '0);

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultEvt != '0) |=> ((statQ & evtMap($past(faultEvt))) == evtMap($past(faultEvt))));

  assert_stuck_resb_R10: assert property (@(posedge clk) disable iff (!rstN)
    stuckOnes |-> !resbQ);

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadStatus, loadData, shiftOut}));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk uChk (
  .clk(clk), .rstN(rstN), .commit(stb.commit), .reject(stb.reject),
  .loadStatus(stb.loadStatus), .loadData(stb.loadData), .shiftOut(stb.shiftOut),
  .faultEvt(faultEvt), .statQ(statQ), .tfQ(tfQ), .resbQ(resbQ),
  .ctrlOut(ctrlOut), .cfgOut(cfgOut), .stuckOnes(stuckOnes)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
  timeunit 1ns; timeprecision 1ps;
  import spi_cmd_pkg::*;

  localparam int HALF = 6; // system clocks per serial half period

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, sclk = 1'b0, csN = 1'b1, sdi = 1'b0;
  logic [5:0] faultEvt = '0;
  logic tsdIn = 1'b0, nrdyIn = 1'b1;
  logic sdo, sdoOe, stuckOnes;
  logic [15:0] ctrlOut, cfgOut;

  spi_cmd_slave dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .sdo(sdo),
    .sdoOe(sdoOe), .faultEvt(faultEvt), .tsdIn(tsdIn), .nrdyIn(nrdyIn),
    .ctrlOut(ctrlOut), .cfgOut(cfgOut), .stuckOnes(stuckOnes)
  );

  int nCmp = 0, nBad = 0, stuckSeen = 0;
  logic busy = 1'b0;

  // Behavioural reference state.
  logic [15:0] mCtrl = '0, mCfg = '0, mStat = '0;
  logic mTf = 1'b0, mResb = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check("R1 sdoOe follows csN", {31'b0, sdoOe}, {31'b0, ~csN});
      if (!busy) begin
        check("R5 ctrlOut vs model", {16'b0, ctrlOut}, {16'b0, mCtrl});
        check("R5 cfgOut vs model", {16'b0, cfgOut}, {16'b0, mCfg});
      end
      if (stuckOnes) stuckSeen++;
    end
  end

  function automatic logic [15:0] mapEvt(input logic [5:0] e);
    logic [15:0] m = '0;
    m[7:4] = e[5:2];
    m[1:0] = e[1:0];
    return m;
  endfunction

  function automatic logic [7:0] modelStatus();
    logic u = |mStat;
    logic f = mTf | ~mResb | tsdIn | u;
    return {f, mTf, mResb, tsdIn, 1'b0, u, 1'b0, nrdyIn};
  endfunction

  function automatic logic [15:0] modelData(input logic [1:0] op, input logic [5:0] a);
    if (op == 2'b11) begin
      case (a)
        6'h00: return 16'h4300;
        6'h01: return 16'h0100;
        6'h02: return 16'h7500;
        6'h03: return 16'h3500;
        6'h3E: return 16'h0200;
        default: return 16'h0000;
      endcase
    end
    case (a)
      6'h00: return mCtrl;
      6'h10: return mStat;
      6'h3F: return mCfg;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic spiFrame(input logic [23:0] tx, input int nClk, input int evtAt,
                          input logic [5:0] evtVal, output logic [23:0] rx);
    rx = '0;
    @(negedge clk); csN = 1'b0;
    if (nClk == 0) begin
      repeat (HALF) @(negedge clk);
      rx[23] = sdo;
    end
    for (int i = 0; i < nClk; i++) begin
      sdi = (i < 24) ? tx[23-i] : 1'b0;
      if (i == evtAt) begin
        faultEvt = evtVal;
        @(negedge clk);
        faultEvt = '0;
        repeat (HALF-1) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      if (i < 24) rx[23-i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1; sdi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic doFrame(input string req, input logic [1:0] op, input logic [5:0] a,
                         input logic [15:0] d, input int nClk = 24, input int evtAt = -1,
                         input logic [5:0] evtVal = '0);
    logic [23:0] tx, rx;
    logic [7:0] expSb;
    logic [15:0] expD, snap;
    int stuck0;
    tx = {op, a, d};
    expSb = modelStatus();
    expD = modelData(op, a);
    snap = mStat;
    stuck0 = stuckSeen;
    busy = 1'b1;
    spiFrame(tx, nClk, evtAt, evtVal, rx);
    if (nClk == 24) check({req, " frame response"}, {8'b0, rx}, {8'b0, expSb, expD});
    else check({req, " R2 fault flag before first rise"}, {31'b0, rx[23]}, {31'b0, expSb[7]});
    if (nClk == 24) begin
      mTf = 1'b0;
      if (tx == 24'hFFFFFF) begin
        mResb = 1'b0;
        check("R10 stuck pulse count", stuckSeen - stuck0, 1);
      end else begin
        mResb = 1'b1;
        check("R10 no stuck pulse", stuckSeen - stuck0, 0);
        if (op == 2'b00 && a == 6'h00) mCtrl = d & 16'h03DF;
        if (op == 2'b00 && a == 6'h3F) mCfg = d & 16'hFFF8;
        if (op == 2'b10 && a == 6'h10) mStat = mStat & ~snap;
      end
    end else if (nClk != 0) begin
      mTf = 1'b1;
    end
    if (evtAt >= 0) mStat = mStat | mapEvt(evtVal);
    busy = 1'b0;
  endtask

  task automatic pulseEvt(input logic [5:0] e);
    @(negedge clk); faultEvt = e;
    @(negedge clk); faultEvt = '0;
    mStat = mStat | mapEvt(e);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 reset ctrl", {16'b0, ctrlOut}, 32'h0);
    check("R3 reset cfg", {16'b0, cfgOut}, 32'h0);
    check("R1 idle sdoOe low", {31'b0, sdoOe}, 32'h0);

    doFrame("R2 poll after reset", 2'b01, 6'h00, 16'h0, 0);
    doFrame("R3 status byte 81h after reset R4 read ctrl", 2'b01, 6'h00, 16'h0);
    doFrame("R5 write ctrl masked", 2'b00, 6'h00, 16'hFFFF);
    nrdyIn = 1'b0;
    doFrame("R5 write returns previous ctrl R11", 2'b00, 6'h00, 16'h0123);
    doFrame("R5 write cfg masked", 2'b00, 6'h3F, 16'hABCD);
    doFrame("R4 read cfg", 2'b01, 6'h3F, 16'h0000);
    doFrame("R5 write to status ignored", 2'b00, 6'h10, 16'hFFFF);
    doFrame("R5 status still zero", 2'b01, 6'h10, 16'h0);
    doFrame("R4 unmapped address reads zero", 2'b01, 6'h05, 16'h0);
    doFrame("R6 short frame rejected", 2'b00, 6'h00, 16'h0000, 23);
    doFrame("R6 tf shown after short frame", 2'b01, 6'h00, 16'h0);
    doFrame("R6 long frame rejected", 2'b00, 6'h3F, 16'h0000, 25);
    doFrame("R2 poll shows fault with tf", 2'b01, 6'h00, 16'h0, 0);
    doFrame("R6 tf after long frame", 2'b01, 6'h3F, 16'h0);
    doFrame("R2 poll keeps tf clear", 2'b01, 6'h00, 16'h0, 0);
    doFrame("R6 tf stays clear after poll", 2'b01, 6'h00, 16'h0);
    doFrame("R7 id 00h", 2'b11, 6'h00, 16'h0);
    doFrame("R7 id 01h", 2'b11, 6'h01, 16'h0);
    doFrame("R7 id 02h", 2'b11, 6'h02, 16'h0);
    doFrame("R7 id 03h", 2'b11, 6'h03, 16'h0);
    doFrame("R7 id 3Eh", 2'b11, 6'h3E, 16'h0);
    doFrame("R7 id unused 04h", 2'b11, 6'h04, 16'h0);
    pulseEvt(6'b100001);
    doFrame("R2 poll shows event fault", 2'b01, 6'h00, 16'h0, 0);
    doFrame("R8 read status after events", 2'b01, 6'h10, 16'h0);
    doFrame("R8 read keeps status", 2'b10, 6'h00, 16'h0);
    doFrame("R9 read-and-clear status with late event", 2'b10, 6'h10, 16'h0, 24, 12, 6'b000010);
    doFrame("R9 only late event left", 2'b01, 6'h10, 16'h0);
    doFrame("R9 short clear frame ignored", 2'b10, 6'h10, 16'h0, 10);
    doFrame("R9 status after ignored clear", 2'b01, 6'h10, 16'h0);
    doFrame("R9 clear remaining bit", 2'b10, 6'h10, 16'h0);
    tsdIn = 1'b1;
    doFrame("R3 thermal bit in status byte", 2'b01, 6'h00, 16'h0);
    tsdIn = 1'b0;
    doFrame("R10 all ones frame", 2'b11, 6'h3F, 16'hFFFF);
    doFrame("R10 resb cleared and regs kept", 2'b01, 6'h3F, 16'h0);
    doFrame("R10 resb set again", 2'b01, 6'h00, 16'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule